// File: doc/BRIEF.md
# Slope-Justified Duty-Cycle Level Scheduler

This block drives the level code of one multilevel inverter phase, one modulation period at a time. When a new period starts, it takes three inputs: a signed fixed-point reference, the reference of the previous period, and the period length in clock ticks. It splits the reference into an integer level index and a fraction. The two candidate levels are the floor and the ceiling of the reference. The block then sets the tick at which the output moves from one level to the other, so that the mean over the period equals the reference.

The slope of the reference decides which level comes first. A rising reference puts the lower level first and the upper level after it. A flat or falling reference puts the upper level first and the lower level after it. Because of this, consecutive periods join with no two-level jump at the seam. A level code moves at most once inside a period. Strobes mark the first tick and the last tick of every period. A ready flag shows when the next period may be loaded, and the last tick of a period counts as ready, so periods can run back to back. Three tasks sit in other blocks: estimating the slope, choosing the period length, and turning the level code into gate signals.

Top module: `duty_level_sched`

## Requirements
- R1: After reset, `level` is 0, `ready` is 1, and `per_start` and `per_end` are 0.
- R2: `ref_now` is two's complement with FRAC_W fraction bits: bits [REF_W-1:FRAC_W] hold the level index and bits [FRAC_W-1:0] hold the duty fraction f. The low level is floor(ref), which means arithmetic truncation toward minus infinity, so -1.25 gives -2 with f = 0.75. The high level is the low level plus one.
- R3: If `ref_now` > `ref_prev` (signed), the low level is output for the first tc = floor((1 - f) * T) ticks and the high level for the rest of the period.
- R4: If `ref_now` <= `ref_prev`, including equal values, the high level is output for the first tc = floor(f * T) ticks and the low level for the rest.
- R5: Tick k of a period (k = 0 .. T-1) shows the first level when k < tc and the second level otherwise. When tc is 0, the second level is shown from tick 0.
- R6: When f is 0, the output holds the single exact level for the whole period and does not commutate.
- R7: Both candidate levels saturate to the range -MAX_LVL .. +MAX_LVL (±4 by default) before use.
- R8: `per_start` is high only on tick 0 and `per_end` is high only on tick T-1. `ready` is high on tick T-1 and whenever the block is idle. A start seen while `ready` is high begins a new period on the next cycle.
- R9: `start` has no effect when `ready` is low or when `period` is 0.
- R10: While idle, `level` holds the last level of the previous period.
- R11: Within one period, `level` changes by at most one step between consecutive ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to load a new period |
| ref_now | input | REF_W | Signed reference for the coming period |
| ref_prev | input | REF_W | Signed reference of the previous period |
| period | input | PER_W | Period length in ticks |
| level | output | LVL_W | Signed output level code |
| per_start | output | 1 | High on the first tick of a period |
| per_end | output | 1 | High on the last tick of a period |
| ready | output | 1 | A start is accepted in this cycle |

## Verification
A start sampled at a clock edge produces tick 0 on the cycle that follows. From that edge on, `level`, `per_start`, `per_end` and `ready` all follow the tick counter with no further delay. The bench changes inputs only on falling edges. It checks every tick of every period at the falling edge, against the level for that tick index, which it works out from floor, fraction and slope. When a period is chained, the bench raises `start` on the falling edge of the last tick of the previous period, so the new tick 0 is due exactly one edge later. When `start` is sent while busy or with a zero period, it is checked on the ticks and idle cycles that follow, where it must leave the schedule and the held level unchanged.

// File: rtl/duty_level_sched.sv
`timescale 1ns/1ps
module duty_level_sched #(
  parameter int REF_W   = 16,
  parameter int FRAC_W  = 8,
  parameter int PER_W   = 12,
  parameter int MAX_LVL = 4,
  localparam int LVL_W  = $clog2(MAX_LVL + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic signed [REF_W-1:0] ref_now,
  input  logic signed [REF_W-1:0] ref_prev,
  input  logic [PER_W-1:0]        period,
  output logic signed [LVL_W-1:0] level,
  output logic                    per_start,
  output logic                    per_end,
  output logic                    ready
);
  localparam int IDX_W = REF_W - FRAC_W;
  localparam logic [FRAC_W:0] ONE = (FRAC_W + 1)'(1) << FRAC_W;

  function automatic logic signed [LVL_W-1:0] clamp(input logic signed [IDX_W:0] v);
    if (v > IDX_W'(MAX_LVL)) return LVL_W'(MAX_LVL);
    if (v < -(IDX_W + 1)'(MAX_LVL)) return -LVL_W'(MAX_LVL);
    return LVL_W'(v);
  endfunction

  logic signed [IDX_W-1:0]       idx;
  logic [FRAC_W-1:0]             frac;
  logic signed [IDX_W:0]         lo_w, hi_w;
  logic signed [LVL_W-1:0]       lo_c, hi_c;
  logic                          rising, accept, last_tick;
  logic [FRAC_W:0]               dur;
  logic [FRAC_W+PER_W:0]         prod;

  logic                          busy;
  logic [PER_W-1:0]              cnt, per_q;
  logic [PER_W:0]                tc_q;
  logic signed [LVL_W-1:0]       first_q, second_q, last_q;

  assign idx    = ref_now[REF_W-1:FRAC_W];
  assign frac   = ref_now[FRAC_W-1:0];
  assign lo_w   = {idx[IDX_W-1], idx};
  assign hi_w   = (frac != '0) ? lo_w + 1'b1 : lo_w;
  assign lo_c   = clamp(lo_w);
  assign hi_c   = clamp(hi_w);
  assign rising = ref_now > ref_prev;
  assign dur    = rising ? ONE - {1'b0, frac} : {1'b0, frac};
  assign prod   = dur * period;

  assign last_tick = busy && (cnt == per_q - 1'b1);
  assign ready     = !busy || last_tick;
  assign accept    = start && ready && (period != '0);
  assign per_start = busy && (cnt == '0);
  assign per_end   = last_tick;
  assign level     = !busy ? last_q : (({1'b0, cnt} >= tc_q) ? second_q : first_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      per_q    <= '0;
      tc_q     <= '0;
      first_q  <= '0;
      second_q <= '0;
      last_q   <= '0;
    end else begin
      last_q <= level;
      if (accept) begin
        busy     <= 1'b1;
        cnt      <= '0;
        per_q    <= period;
        tc_q     <= prod[FRAC_W+PER_W:FRAC_W];
        first_q  <= rising ? lo_c : hi_c;
        second_q <= rising ? hi_c : lo_c;
      end else if (last_tick) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R11
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !per_start) |-> ((level - $past(level)) inside {-1, 0, 1}));

  // R7
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level <= LVL_W'(MAX_LVL)) && (level >= -LVL_W'(MAX_LVL)));

  // R9
  ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_tick && start) |=> !per_start);

  // R9
  zero_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (period == '0)) |=> !busy);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !accept) |=> $stable(level));

  // R6
  flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !per_start && (first_q == second_q)) |-> $stable(level));

  // R8
  end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_end && !start) |=> (!per_start && ready));
endmodule

// File: tb/test_duty_level_sched.sv
`timescale 1ns/1ps
module test_duty_level_sched;
  localparam int F = 8;
  localparam int MAXL = 4;

  logic clk = 0, rst_n = 0, start = 0;
  logic signed [15:0] ref_now = '0, ref_prev = '0;
  logic [11:0] period = '0;
  logic signed [3:0] level;
  logic per_start, per_end, ready;
  int checks = 0, errors = 0, exp_last = 0;

  always #10 clk = ~clk;

  duty_level_sched i_duty_level_sched (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_now(ref_now), .ref_prev(ref_prev),
    .period(period), .level(level), .per_start(per_start), .per_end(per_end), .ready(ready));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int sat(input int v);
    return v > MAXL ? MAXL : (v < -MAXL ? -MAXL : v);
  endfunction

  // Drives a period from a falling edge; glitch_at > 0 sends an ignored start mid-period (R9)
  task automatic do_period(input int rn, input int rp, input int t, input int glitch_at, input string req);
    int lo, fr, hi, tc, fst, snd, e;
    bit rise;
    lo = (rn >= 0) ? rn / (1 << F) : -((-rn + (1 << F) - 1) / (1 << F));
    fr = rn - lo * (1 << F);
    hi = (fr != 0) ? lo + 1 : lo;
    rise = rn > rp;
    tc = rise ? int'((longint'((1 << F) - fr) * t) / (1 << F)) : int'((longint'(fr) * t) / (1 << F));
    fst = sat(rise ? lo : hi);
    snd = sat(rise ? hi : lo);
    start = 1; ref_now = 16'(rn); ref_prev = 16'(rp); period = 12'(t);
    for (int k = 0; k < t; k++) begin
      @(negedge clk);
      if (k == 0) start = 0;
      if (glitch_at > 0 && k == glitch_at) begin
        start = 1; ref_now = 16'sh7fff; ref_prev = 16'sh8000; period = 12'd3;
      end
      if (glitch_at > 0 && k == glitch_at + 1) start = 0;
      e = (k < tc) ? fst : snd;
      chk(int'(level) == e, req, int'(level), e);
      chk(per_start == (k == 0), "R8 per_start", int'(per_start), int'(k == 0));
      chk(per_end == (k == t - 1), "R8 per_end", int'(per_end), int'(k == t - 1));
      chk(ready == (k == t - 1), "R8 ready", int'(ready), int'(k == t - 1));
    end
    exp_last = snd;
  endtask

  task automatic idle(input int n, input bit zero_start);
    for (int k = 0; k < n; k++) begin
      if (zero_start && k == 0) begin start = 1; period = '0; ref_now = 16'sh0300; end
      @(negedge clk);
      if (k == 0) start = 0;
      chk(int'(level) == exp_last, "R10 idle hold", int'(level), exp_last);
      chk(ready && !per_start && !per_end, "R9/R10 idle flags", int'({ready, per_start, per_end}), 4);
    end
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(level == 0, "R1 level", int'(level), 0);
    chk(ready == 1, "R1 ready", int'(ready), 1);
    chk(!per_start && !per_end, "R1 strobes", int'({per_start, per_end}), 0);
    rst_n = 1;
    idle(2, 0);
    do_period(2 * 256 + 64, 0, 8, 0, "R3 rising 2.25");          // tc=6 lo=2
    idle(2, 0);
    do_period(256 + 192, 3 * 256, 8, 0, "R4 falling 1.75");       // tc=6 hi=2
    idle(1, 0);
    do_period(384, 384, 10, 0, "R4 equal 1.5");                   // tc=5
    idle(1, 0);
    do_period(-320, -1000, 16, 0, "R2 negative floor -1.25");     // lo=-2 tc=4
    idle(1, 0);
    do_period(768, 0, 5, 0, "R6 exact rising");
    do_period(768, 1024, 5, 0, "R6 exact falling");
    idle(1, 0);
    do_period(6 * 256 + 128, 0, 6, 0, "R7 positive saturation");
    do_period(-7 * 256, 0, 6, 0, "R7 negative saturation");
    idle(1, 0);
    do_period(256 + 85, 512, 7, 0, "R5 truncated tick");          // tc=2
    do_period(2 * 256 + 64, 256, 1, 0, "R5 single tick tc=0");    // R8 chained
    do_period(-128, 0, 4, 0, "R8 chained -0.5");
    do_period(512 + 32, -128, 9, 3, "R9 start while busy");
    idle(3, 1);
    idle(2, 0);
    do_period(-3 * 256 - 200, 0, 12, 5, "R9 busy start negative");
    idle(2, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule